// File: doc/BRIEF.md
# Chopped Conversion Result Combiner

This block sits behind a delta-sigma modulator that runs its internal conversions with alternating input polarity. Each raw conversion carries the wanted signal plus a common offset term. Subtracting a conversion in the negative polarity slot from its neighbour in the positive slot removes that term. The block then halves the difference, which gives an offset-free output sample at the full input resolution.

Two rate modes are supported. In the normal (1X) rate, two fresh conversions are paired for every output, so outputs come at half the conversion rate and never carry stale data. In the double (2X) rate, every conversion is combined with the one before it as a running average, so the output rate is doubled. In 2X the block flags outputs that mix data from two different input channels. A new configuration (channel and 5-bit speed code) is taken on a strobe. The block also raises a one-cycle request telling the input multiplexer when it may switch.

Top module: `chop_combiner`

## Requirements
- R1: While reset is high and on the first cycle after it, res_vld, res_bad, mux_req and res_data are all 0. Reset loads channel 0 and speed code 0 (1X), clears the history and makes the next conversion a positive-slot conversion.
- R2: The rate is bit 0 of the 5-bit speed code (0 = 1X, 1 = 2X). It is taken together with the channel when cfg_strobe is high.
- R3: In 1X, res_vld pulses one cycle after every second conversion. res_data = (P − N) >>> 1, computed at 25 bits with an arithmetic shift (floor). P is the conversion in the positive slot and N the one in the negative slot. Slots alternate, and the first conversion after reset or after a pairing restart is positive.
- R4: A strobe that selects 1X and changes the channel or any speed bit restarts pairing. A held half pair is dropped and the next conversion is positive. A strobe that repeats the active settings leaves the pair intact. 1X outputs never have res_bad set.
- R5: In 2X, res_vld pulses one cycle after every conversion. The new conversion is combined with the previous one using the slot rule of R3, and slots keep alternating across strobes that select 2X.
- R6: The first 2X output after reset has res_bad = 1.
- R7: After a strobe that changes the channel, the next 2X output has res_bad = 1 and later outputs have res_bad = 0.
- R8: After a strobe in 2X that changes only speed bits other than the rate bit, the next output has res_bad = 0.
- R9: Changing only the rate bit, in either direction, gives a first result with res_bad = 0.
- R10: mux_req pulses for one cycle one cycle after each 2X conversion. It also pulses one cycle after a strobe that selects 1X with a channel different from the active one. When both fall in the same cycle, a single pulse results.
- R11: A conversion arriving in the same cycle as cfg_strobe is processed under the old configuration. The strobe's effects apply from the next conversion on.
- R12: Full-scale inputs do not overflow. P = 8388607 with N = −8388608 gives 8388607, and P = −8388608 with N = 8388607 gives −8388608.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_vld | input | 1 | Raw conversion present this cycle |
| raw_data | input | 24 | Signed raw conversion |
| cfg_strobe | input | 1 | Take cfg_chan and cfg_speed |
| cfg_chan | input | 4 | Requested input channel |
| cfg_speed | input | 5 | Speed code, bit 0 selects 2X |
| res_data | output | 24 | Signed offset-free result |
| res_vld | output | 1 | Result present this cycle |
| res_bad | output | 1 | Result mixes two channels |
| mux_req | output | 1 | Input multiplexer may switch now |

## Verification
The two functions that can land in the same cycle are conversion processing and configuration capture. A raw conversion and cfg_strobe are driven on the same clock edge while in 2X, with the strobe moving to 1X on a new channel. The bench judges this case in three ways. The coincident conversion must still produce a 2X output with its old-configuration flag. Exactly one mux_req pulse must appear for the two causes. The next two conversions must form a fresh 1X pair.

// File: rtl/chop_pkg.sv
package chop_pkg;
  typedef enum logic {SLOT_POS = 1'b0, SLOT_NEG = 1'b1} slot_e;
endpackage

// File: rtl/chop_cfg_reg.sv
module chop_cfg_reg #(
  parameter int CHW      = 4,
  parameter int SPW      = 5,
  parameter int RATE_BIT = 0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_strobe,
  input  logic [CHW-1:0] cfg_chan,
  input  logic [SPW-1:0] cfg_speed,
  output logic           act_2x,
  output logic           new_2x,
  output logic           chan_diff,
  output logic           any_diff
);
  logic [CHW-1:0] act_chan;
  logic [SPW-1:0] act_speed;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_chan  <= '0;
      act_speed <= '0;
    end else if (cfg_strobe) begin
      act_chan  <= cfg_chan;
      act_speed <= cfg_speed;
    end
  end

  always_comb begin
    act_2x    = act_speed[RATE_BIT];
    new_2x    = cfg_speed[RATE_BIT];
    chan_diff = cfg_strobe && (cfg_chan != act_chan);
    any_diff  = cfg_strobe && ((cfg_chan != act_chan) || (cfg_speed != act_speed));
  end
endmodule

// File: rtl/chop_track.sv
module chop_track
  import chop_pkg::*;
#(
  parameter int DW = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 raw_vld,
  input  logic signed [DW-1:0] raw_data,
  input  logic                 restart,
  input  logic                 chan_diff,
  output logic signed [DW-1:0] prev,
  output slot_e                slot,
  output logic                 have_hist,
  output logic                 stale
);
  always_ff @(posedge clk) begin
    if (rst) begin
      prev      <= '0;
      slot      <= SLOT_POS;
      have_hist <= 1'b0;
      stale     <= 1'b0;
    end else begin
      if (raw_vld) begin
        prev      <= raw_data;
        have_hist <= 1'b1;
      end
      if (restart)
        slot <= SLOT_POS;
      else if (raw_vld)
        slot <= (slot == SLOT_POS) ? SLOT_NEG : SLOT_POS;
      if (chan_diff)
        stale <= 1'b1;
      else if (raw_vld)
        stale <= 1'b0;
    end
  end
endmodule

// File: rtl/chop_combine.sv
module chop_combine
  import chop_pkg::*;
#(
  parameter int DW = 24
) (
  input  logic signed [DW-1:0] cur,
  input  logic signed [DW-1:0] prev,
  input  slot_e                cur_slot,
  output logic signed [DW-1:0] result
);
  localparam int SW = DW + 1;
  logic signed [SW-1:0] pos_x, neg_x, diff;

  always_comb begin
    if (cur_slot == SLOT_POS) begin
      pos_x = {cur[DW-1], cur};
      neg_x = {prev[DW-1], prev};
    end else begin
      pos_x = {prev[DW-1], prev};
      neg_x = {cur[DW-1], cur};
    end
    diff   = pos_x - neg_x;
    result = diff[SW-1:1];
  end
endmodule

// File: rtl/chop_combiner.sv
module chop_combiner
  import chop_pkg::*;
#(
  parameter int DW       = 24,
  parameter int CHW      = 4,
  parameter int SPW      = 5,
  parameter int RATE_BIT = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 raw_vld,
  input  logic signed [DW-1:0] raw_data,
  input  logic                 cfg_strobe,
  input  logic [CHW-1:0]       cfg_chan,
  input  logic [SPW-1:0]       cfg_speed,
  output logic signed [DW-1:0] res_data,
  output logic                 res_vld,
  output logic                 res_bad,
  output logic                 mux_req
);
  logic                 act_2x, new_2x, chan_diff, any_diff, restart;
  logic signed [DW-1:0] prev, comb;
  slot_e                slot;
  logic                 have_hist, stale, emit;

  chop_cfg_reg #(.CHW(CHW), .SPW(SPW), .RATE_BIT(RATE_BIT)) u_cfg (
    .clk(clk), .rst(rst), .cfg_strobe(cfg_strobe), .cfg_chan(cfg_chan),
    .cfg_speed(cfg_speed), .act_2x(act_2x), .new_2x(new_2x),
    .chan_diff(chan_diff), .any_diff(any_diff)
  );

  assign restart = any_diff && !new_2x;

  chop_track #(.DW(DW)) u_track (
    .clk(clk), .rst(rst), .raw_vld(raw_vld), .raw_data(raw_data),
    .restart(restart), .chan_diff(chan_diff), .prev(prev), .slot(slot),
    .have_hist(have_hist), .stale(stale)
  );

  chop_combine #(.DW(DW)) u_comb (
    .cur(raw_data), .prev(prev), .cur_slot(slot), .result(comb)
  );

  assign emit = raw_vld && (act_2x || (slot == SLOT_NEG));

  always_ff @(posedge clk) begin
    if (rst) begin
      res_data <= '0;
      res_vld  <= 1'b0;
      res_bad  <= 1'b0;
      mux_req  <= 1'b0;
    end else begin
      res_vld <= emit;
      res_bad <= emit && act_2x && (!have_hist || stale);
      if (emit)
        res_data <= comb;
      mux_req <= (raw_vld && act_2x) || (chan_diff && !new_2x);
    end
  end
endmodule

// File: rtl/chop_combiner_chk.sv
module chop_combiner_chk #(
  parameter int DW = 24
) (
  input logic          clk,
  input logic          rst,
  input logic          raw_vld,
  input logic          act_2x,
  input logic [DW-1:0] res_data,
  input logic          res_vld,
  input logic          res_bad,
  input logic          mux_req
);
  // R3: a result only follows a conversion
  p_out_after_raw_r3: assert property (@(posedge clk) disable iff (rst)
    res_vld |-> $past(raw_vld));
  // R7: the bad marker only accompanies a result
  p_bad_with_vld_r7: assert property (@(posedge clk) disable iff (rst)
    res_bad |-> res_vld);
  // R4: results from the 1X rate are never marked bad
  p_no_bad_1x_r4: assert property (@(posedge clk) disable iff (rst)
    (raw_vld && !act_2x) |=> !res_bad);
  // R5: every 2X conversion yields a result
  p_out_each_2x_r5: assert property (@(posedge clk) disable iff (rst)
    (raw_vld && act_2x) |=> res_vld);
  // R10: every 2X conversion requests a multiplexer switch
  p_mux_each_2x_r10: assert property (@(posedge clk) disable iff (rst)
    (raw_vld && act_2x) |=> mux_req);
  // R3: the result holds its value between results
  p_hold_data_r3: assert property (@(posedge clk) disable iff (rst)
    !res_vld |-> $stable(res_data));
endmodule

bind chop_combiner chop_combiner_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .raw_vld(raw_vld), .act_2x(act_2x),
  .res_data(res_data), .res_vld(res_vld), .res_bad(res_bad), .mux_req(mux_req)
);

// File: tb/chop_combiner_tb_top.sv
module chop_combiner_tb_top;
  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               raw_vld = 1'b0;
  logic signed [23:0] raw_data = '0;
  logic               cfg_strobe = 1'b0;
  logic [3:0]         cfg_chan = '0;
  logic [4:0]         cfg_speed = '0;
  logic signed [23:0] res_data;
  logic               res_vld, res_bad, mux_req;

  always #10 clk = ~clk;

  chop_combiner dut_i (
    .clk(clk), .rst(rst), .raw_vld(raw_vld), .raw_data(raw_data),
    .cfg_strobe(cfg_strobe), .cfg_chan(cfg_chan), .cfg_speed(cfg_speed),
    .res_data(res_data), .res_vld(res_vld), .res_bad(res_bad), .mux_req(mux_req)
  );

  typedef struct { logic [23:0] d; logic bad; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, failures = 0, mux_seen = 0, exp_mux = 0;

  // requirement-based model state
  bit               m_2x, m_slot, m_have, m_stale;
  logic [3:0]       m_chan;
  logic [4:0]       m_spd;
  logic signed [23:0] m_prev;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_2x = 0; m_slot = 0; m_have = 0; m_stale = 0;
    m_chan = '0; m_spd = '0; m_prev = '0;
  endtask

  task automatic step(input bit do_raw, input logic signed [23:0] d,
                      input bit do_cfg, input logic [3:0] ch, input logic [4:0] sp,
                      input string tag);
    logic signed [24:0] p, n, df;
    bit mux_now;
    exp_t e;
    @(negedge clk);
    raw_vld = do_raw; raw_data = d;
    cfg_strobe = do_cfg; cfg_chan = ch; cfg_speed = sp;
    mux_now = 0;
    if (do_raw) begin
      if (!m_slot) begin p = {d[23], d}; n = {m_prev[23], m_prev}; end
      else begin p = {m_prev[23], m_prev}; n = {d[23], d}; end
      df = p - n;
      if (m_2x || m_slot) begin
        e.d = df[24:1]; e.bad = m_2x && (!m_have || m_stale); e.tag = tag;
        q.push_back(e);
      end
      if (m_2x) mux_now = 1;
      m_prev = d; m_have = 1; m_stale = 0; m_slot = ~m_slot;
    end
    if (do_cfg) begin
      if (!sp[0] && ch != m_chan) mux_now = 1;
      if (!sp[0] && (ch != m_chan || sp != m_spd)) m_slot = 0;
      if (ch != m_chan) m_stale = 1;
      m_chan = ch; m_spd = sp; m_2x = sp[0];
    end
    if (mux_now) exp_mux++;
    @(negedge clk);
    raw_vld = 0; cfg_strobe = 0;
  endtask

  task automatic conv(input logic signed [23:0] d, input string tag);
    step(1, d, 0, 4'd0, 5'd0, tag);
  endtask

  task automatic cfg(input logic [3:0] ch, input logic [4:0] sp, input string tag);
    step(0, '0, 1, ch, sp, tag);
  endtask

  task automatic chk_mux(input string tag);
    @(negedge clk); @(negedge clk);
    chk(tag, mux_seen, exp_mux);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (mux_req) mux_seen++;
      if (res_vld) begin
        if (q.size() == 0) begin
          checks++; failures++;
          $display("FAIL R3 actual=unexpected_result expected=none");
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(e.tag, {7'd0, res_bad, res_data}, {7'd0, e.bad, e.d});
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin @(posedge clk); cyc++; end
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", {res_vld, res_bad, mux_req}, 3'b000);
    rst = 0;
    @(negedge clk);
    chk("R1", {8'd0, res_data}, 32'd0);
    chk("R1", {res_vld, res_bad, mux_req}, 3'b000);

    // R3: 1X pairs
    conv(24'sd1000, "R3"); conv(24'sd200, "R3");
    conv(-24'sd50, "R3");  conv(24'sd51, "R3");
    // R12: full scale
    conv(24'sh7FFFFF, "R12"); conv(24'sh800000, "R12");
    conv(24'sh800000, "R12"); conv(24'sh7FFFFF, "R12");

    // R4: same-settings strobe keeps pair, changed settings restart it
    conv(24'sd10, "R4"); cfg(4'd0, 5'd0, "R4"); conv(24'sd4, "R4");
    conv(24'sd77, "R4"); cfg(4'd3, 5'd0, "R4");
    conv(24'sd100, "R4"); conv(24'sd40, "R4");
    chk_mux("R10");

    // R9 / R2: rate-only change 1X -> 2X, bit 0 selects 2X
    cfg(4'd3, 5'b00001, "R2");
    conv(24'sd20, "R9"); conv(24'sd60, "R5"); conv(24'sd30, "R5");
    chk_mux("R10");

    // R8: speed-only change in 2X
    cfg(4'd3, 5'b00101, "R8");
    conv(-24'sd300, "R8"); conv(24'sd5, "R5");

    // R7: channel change in 2X
    cfg(4'd5, 5'b00101, "R7");
    conv(24'sd1234, "R7"); conv(24'sd1000, "R7"); conv(-24'sd8, "R7");
    chk_mux("R10");

    // R9: rate-only change 2X -> 1X, then back
    cfg(4'd5, 5'b00100, "R9");
    conv(24'sd900, "R9"); conv(24'sd100, "R9");
    cfg(4'd5, 5'b00101, "R9");
    conv(24'sd150, "R9");

    // R11 / R10: conversion coincident with a strobe to 1X on a new channel
    step(1, 24'sd500, 1, 4'd6, 5'b00100, "R11");
    chk_mux("R10");
    conv(24'sd70, "R11"); conv(24'sd30, "R11");

    // R6: reset, then 2X without history
    @(negedge clk); rst = 1; @(negedge clk); @(negedge clk);
    chk("R1", q.size(), 0);
    rst = 0; model_reset();
    cfg(4'd0, 5'b00001, "R6");
    conv(24'sd40, "R6"); conv(24'sd10, "R6");
    chk_mux("R10");

    repeat (4) @(negedge clk);
    chk("R3", q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule